// File: doc/BRIEF.md
# Shadow RAM Segment Attribute Decoder

This block decides, for each memory access into the upper-memory window from 0xA0000 up to 0xFFFFF, whether the read or write is served by on-board DRAM or passed to the external bus. The window is split into 24 segments of 16 KB. Each segment has a 2-bit attribute. The attributes are packed four to a byte across six control bytes, which reach the block as one flat vector.

An access is described by an address, a valid strobe and a write flag. The block registers one internal-read select and one internal-write select, which appear in the cycle after the access is presented. It also drives two static flags that tell whether the system BIOS area (0xE0000 and up) is shadowed for reads or for writes. These flags depend only on the control bytes.

Top module: `shadow_seg_decode`

## Requirements
- R1: While reset (rstN low) is held and after it is released with no access, intRead and intWrite are 0.
- R2: Control byte k (segCtrl bits [8k+7:8k], k = 0..5) covers addresses 0xA0000 + k*0x10000 up to 64 KB above that. Within that byte, bits [2j+1:2j] cover the 16 KB segment j (j = 0..3), and bits [1:0] cover the lowest segment.
- R3: Attribute bit 1 set means reads of the segment go to internal DRAM. Attribute bit 0 set means writes go to internal DRAM. So 00 sends both to the bus, 01 keeps only writes internal, 10 keeps only reads internal, and 11 keeps both internal.
- R4: A valid read (accWrite = 0) inside the window raises intRead in the next cycle exactly when the segment's bit 1 is set. A valid write (accWrite = 1) raises intWrite exactly when bit 0 is set.
- R5: A read never raises intWrite and a write never raises intRead. With accValid low, both selects are 0 in the next cycle.
- R6: Addresses below 0xA0000 or at or above 0x100000 leave both selects at 0, whatever the control bytes hold.
- R7: biosReadShadow is 1 exactly when some segment at or above 0xE0000 (control bytes 4 and 5) has attribute bit 1 set.
- R8: biosWriteShadow is 1 exactly when some segment at or above 0xE0000 has attribute bit 0 set.
- R9: Attributes of segments below 0xE0000 (control bytes 0 to 3) have no effect on either BIOS flag.
- R10: Each select reflects only the access sampled at the previous clock edge. It falls in the cycle after the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segCtrl | input | 48 | Six control bytes, byte k at bits [8k+7:8k] |
| accValid | input | 1 | Access presented this cycle |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accAddr | input | 24 | Byte address of the access |
| intRead | output | 1 | Registered: read is served by internal DRAM |
| intWrite | output | 1 | Registered: write is served by internal DRAM |
| biosReadShadow | output | 1 | BIOS area has read shadowing in some segment |
| biosWriteShadow | output | 1 | BIOS area has write shadowing in some segment |

## Verification
The hardest cases to reach are the exact segment edges. A misplaced field or an off-by-one window compare only shows when an access lands at the first or last byte of a segment, and a neighbouring segment carries a different attribute at the same time.

The stimulus walks every segment with a one-hot attribute pattern. It probes the segment's own middle and the first byte of the next segment. It then hits 0x9FFFF, 0xA0000, 0xFFFFF and 0x100000 with every attribute set to 11.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned NUM_REGS     = 6;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned FIELD_W      = 2;
  localparam int unsigned SEG_BITS     = 14;
  localparam int unsigned SEGS_PER_REG = REG_W / FIELD_W;
  localparam int unsigned NUM_SEGS     = NUM_REGS * SEGS_PER_REG;
  localparam int unsigned SEG_IDX_W    = $clog2(NUM_SEGS);
  localparam int unsigned CTRL_W       = NUM_REGS * REG_W;

  // strobes from address control to routing datapath
  typedef struct packed {
    logic                 hit;
    logic                 rdReq;
    logic                 wrReq;
    logic [SEG_IDX_W-1:0] segIdx;
  } segStrobe_t;
endpackage

// File: rtl/shadow_addr_ctrl.sv
module shadow_addr_ctrl
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned WIN_BASE = 32'h000A_0000
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output segStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] winLo = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] winHi = ADDR_W'(WIN_BASE + NUM_SEGS * (1 << SEG_BITS));

  logic [ADDR_W-1:0] winOff;
  logic              inWindow;

  always_comb begin
    winOff          = accAddr - winLo;
    inWindow        = (accAddr >= winLo) && (accAddr < winHi);
    strobe.hit      = inWindow;
    strobe.rdReq    = accValid && !accWrite && inWindow;
    strobe.wrReq    = accValid && accWrite && inWindow;
    strobe.segIdx   = winOff[SEG_BITS +: SEG_IDX_W];
  end
endmodule

// File: rtl/shadow_route_dp.sv
module shadow_route_dp
  import shadow_pkg::*;
#(
  parameter int unsigned WIN_BASE  = 32'h000A_0000,
  parameter int unsigned BIOS_BASE = 32'h000E_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] segCtrl,
  input  segStrobe_t        strobe,
  output logic              intRead,
  output logic              intWrite,
  output logic              biosReadShadow,
  output logic              biosWriteShadow
);
  localparam int unsigned BIOS_SEG = (BIOS_BASE - WIN_BASE) >> SEG_BITS;

  logic [FIELD_W-1:0] segAttr [NUM_SEGS];
  logic [NUM_SEGS-1:0] biosRdVec;
  logic [NUM_SEGS-1:0] biosWrVec;
  logic [FIELD_W-1:0] curAttr;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar f = 0; f < SEGS_PER_REG; f++) begin : g_fld
      localparam int unsigned SEG = r * SEGS_PER_REG + f;
      assign segAttr[SEG] = segCtrl[r*REG_W + f*FIELD_W +: FIELD_W];
      if (SEG >= BIOS_SEG) begin : g_bios
        assign biosRdVec[SEG] = segAttr[SEG][1];
        assign biosWrVec[SEG] = segAttr[SEG][0];
      end else begin : g_low
        assign biosRdVec[SEG] = 1'b0;
        assign biosWrVec[SEG] = 1'b0;
      end
    end
  end

  assign curAttr         = strobe.hit ? segAttr[strobe.segIdx] : '0;
  assign biosReadShadow  = |biosRdVec;
  assign biosWriteShadow = |biosWrVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intRead  <= 1'b0;
      intWrite <= 1'b0;
    end else begin
      intRead  <= strobe.rdReq && curAttr[1];
      intWrite <= strobe.wrReq && curAttr[0];
    end
  end

  // R6: no routing outside the window
  p_no_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hit |=> (!intRead && !intWrite));
  // R5: a single access never selects both directions
  p_one_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(intRead && intWrite));
  // R7: BIOS read hit without read shadow flag gives no internal read
  p_bios_rd_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && (32'(strobe.segIdx) >= BIOS_SEG) && !biosReadShadow) |=> !intRead);
  // R8: BIOS write hit without write shadow flag gives no internal write
  p_bios_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrReq && (32'(strobe.segIdx) >= BIOS_SEG) && !biosWriteShadow) |=> !intWrite);
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned WIN_BASE  = 32'h000A_0000,
  parameter int unsigned BIOS_BASE = 32'h000E_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] segCtrl,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              intRead,
  output logic              intWrite,
  output logic              biosReadShadow,
  output logic              biosWriteShadow
);
  segStrobe_t strobe;

  shadow_addr_ctrl #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) ctrl_i (
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr), .strobe(strobe)
  );

  shadow_route_dp #(.WIN_BASE(WIN_BASE), .BIOS_BASE(BIOS_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .segCtrl(segCtrl), .strobe(strobe),
    .intRead(intRead), .intWrite(intWrite),
    .biosReadShadow(biosReadShadow), .biosWriteShadow(biosWriteShadow)
  );

  // R5/R10: an idle cycle leaves no select in the next one
  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!intRead && !intWrite));
endmodule

// File: tb/shadow_seg_decode_tb_top.sv
`timescale 1ns/1ps
module shadow_seg_decode_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] segCtrl = '0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [23:0] accAddr = '0;
  logic        intRead, intWrite, biosReadShadow, biosWriteShadow;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  shadow_seg_decode dut_i (
    .clk(clk), .rstN(rstN), .segCtrl(segCtrl), .accValid(accValid),
    .accWrite(accWrite), .accAddr(accAddr), .intRead(intRead), .intWrite(intWrite),
    .biosReadShadow(biosReadShadow), .biosWriteShadow(biosWriteShadow)
  );

  task automatic check(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // attribute of the segment holding addr, from the requirement text
  function automatic logic [1:0] attrOf(logic [47:0] c, int unsigned a);
    int unsigned off = a - 32'hA0000;
    int unsigned k = off / 32'h10000;
    int unsigned j = (off % 32'h10000) / 32'h4000;
    return c[k*8 + j*2 +: 2];
  endfunction

  function automatic logic inWin(int unsigned a);
    return (a >= 32'hA0000) && (a < 32'h100000);
  endfunction

  task automatic access(string req, int unsigned a, logic wr, logic expR, logic expW);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accAddr = a[23:0];
    @(posedge clk);
    @(negedge clk);
    accValid = 1'b0;
    check(req, $sformatf("intRead addr=%h wr=%b", a, wr), intRead, expR);
    check(req, $sformatf("intWrite addr=%h wr=%b", a, wr), intWrite, expW);
  endtask

  task automatic modelAccess(string req, int unsigned a, logic wr);
    logic [1:0] at = inWin(a) ? attrOf(segCtrl, a) : 2'b00;
    access(req, a, wr, !wr && at[1], wr && at[0]);
  endtask

  task automatic testReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "intRead in reset", intRead, 1'b0);
    check("R1", "intWrite in reset", intWrite, 1'b0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", "intRead after reset", intRead, 1'b0);
    check("R1", "intWrite after reset", intWrite, 1'b0);
  endtask

  task automatic testEncoding();
    for (int code = 0; code < 4; code++) begin
      segCtrl = '0;
      segCtrl[2*9 +: 2] = code[1:0];           // segment 9 = 0xC4000
      access("R3", 32'hC5000, 1'b0, code[1], 1'b0);
      access("R4", 32'hC5000, 1'b1, 1'b0, code[0]);
    end
    segCtrl = '1;
    access("R5", 32'hB0000, 1'b0, 1'b1, 1'b0);
    access("R5", 32'hB0000, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testMapping();
    for (int s = 0; s < 24; s++) begin
      int unsigned base = 32'hA0000 + s * 32'h4000;
      segCtrl = 48'(2'b11) << (2*s);
      access("R2", base + 32'h2000, 1'b0, 1'b1, 1'b0);
      access("R2", base + 32'h3FFF, 1'b1, 1'b0, 1'b1);
      modelAccess("R2", base + 32'h4000, 1'b0);
    end
  endtask

  task automatic testWindow();
    segCtrl = '1;
    access("R6", 32'h9FFFF, 1'b0, 1'b0, 1'b0);
    access("R6", 32'h100000, 1'b1, 1'b0, 1'b0);
    access("R6", 32'h000000, 1'b0, 1'b0, 1'b0);
    access("R6", 32'hFFFFFF, 1'b1, 1'b0, 1'b0);
    access("R2", 32'hA0000, 1'b0, 1'b1, 1'b0);
    access("R2", 32'hFFFFF, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testIdleLatency();
    segCtrl = '1;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; accAddr = 24'hC0000;
    @(posedge clk); @(negedge clk);
    check("R5", "intRead with accValid low", intRead, 1'b0);
    check("R5", "intWrite with accValid low", intWrite, 1'b0);
    access("R10", 32'hD0000, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R10", "intRead drops after access", intRead, 1'b0);
  endtask

  task automatic testBiosFlags();
    segCtrl = 48'h0000_FFFF_FFFF;
    #1;
    check("R9", "biosReadShadow low bytes only", biosReadShadow, 1'b0);
    check("R9", "biosWriteShadow low bytes only", biosWriteShadow, 1'b0);
    segCtrl = 48'h0002_0000_0000;              // byte4 seg0 = 10
    #1;
    check("R7", "biosReadShadow byte4 10", biosReadShadow, 1'b1);
    check("R8", "biosWriteShadow byte4 10", biosWriteShadow, 1'b0);
    segCtrl = 48'h4000_0000_0000;              // byte5 seg3 = 01
    #1;
    check("R7", "biosReadShadow byte5 01", biosReadShadow, 1'b0);
    check("R8", "biosWriteShadow byte5 01", biosWriteShadow, 1'b1);
    segCtrl = 48'hC000_0000_0000;
    #1;
    check("R7", "biosReadShadow byte5 11", biosReadShadow, 1'b1);
    check("R8", "biosWriteShadow byte5 11", biosWriteShadow, 1'b1);
    access("R8", 32'hFC000, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    testReset();
    testEncoding();
    testMapping();
    testWindow();
    testIdleLatency();
    testBiosFlags();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule